// File: doc/BRIEF.md
# Two-Wire Serial Programming Target Interface

This block sits on the device side of a two-wire programming link. The link has one clock input driven by the external programmer and one data line that both sides share. The block brings both wires into the system clock domain and finds the clock edges. It shifts in a six-bit command on falling edges and decodes it. For commands that carry a word, it then either captures a sixteen-clock load frame or drives the data line during a read frame.

Downstream, the block hands an executor a one-cycle command strobe, a three-bit command code and, for loads, the fourteen-bit word. For reads it takes a fourteen-bit word back and serialises it onto the data line. It also drives the output enable of the data pad.

A level input marks that the device is in programming mode. While that level is low, the block is held in its idle command-receive state. When the level drops in the middle of a transfer, the transfer is abandoned.

Top module: `prog_link_target`

## Requirements
- R1: While rstN is low, or while inMode is low, pgmDatOe stays 0 and cmdValid stays 0.
- R2: A command is six bits on pgmDatIn, sampled at six successive falling edges of pgmClk, least-significant bit first. Each command without a data frame gives exactly one cmdValid pulse once its sixth bit is taken. The decode is on the 6-bit value c[5:0]:
  - c[3:0]=0110 is increment (cmdCode 3).
  - c[3:0]=1001 is bulk erase (cmdCode 6).
  - c[4:0]=11000 is begin programming (cmdCode 4).
  - c[4:0]=01010 is end programming (cmdCode 5).
  - c[4:0]=10001 is row erase (cmdCode 7).
- R3: Bits above a command's defined field are don't-care. For four-bit codes, c[5:4] have no effect. For five-bit codes, c[5] has no effect.
- R4: A six-bit value that matches no code gives no strobe. It is consumed whole, and the next six falling edges form a new command.
- R5: c[3:0]=0000 (load configuration, cmdCode 0) and c[3:0]=0010 (load program data, cmdCode 1) are each followed by a sixteen-clock frame. The bits at falling edges 2 to 15 form cmdWord, least-significant bit first. The bits at edges 1 and 16 are ignored. The cmdValid pulse comes after the sixteenth falling edge, with cmdWord valid in the same cycle.
- R6: c[3:0]=0100 (read, cmdCode 2) pulses cmdValid when the command completes. rdData is taken at the first rising edge of the following frame. At rising edge k of the frame (k = 2 to 15), pgmDatOut presents bit k-2 of that word.
- R7: pgmDatOe is 1 only from the second rising edge to the sixteenth rising edge of a read frame. It is 0 at all other times, including after the first rising edge and after the sixteenth.
- R8: Dropping inMode at any point abandons the current command or frame. It releases the data line and gives no strobe for the abandoned transfer. Once inMode returns, the next falling edge is the first bit of a new command.
- R9: cmdValid never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the programming clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inMode | input | 1 | High while the device is in programming mode |
| pgmClk | input | 1 | Programming clock from the external programmer |
| pgmDatIn | input | 1 | Data line as seen at the pad input |
| rdData | input | 14 | Word returned by the executor for a read |
| pgmDatOut | output | 1 | Value driven onto the data line |
| pgmDatOe | output | 1 | Output enable of the data pad |
| cmdValid | output | 1 | One-cycle strobe for a decoded command |
| cmdCode | output | 3 | Code of the strobed command |
| cmdWord | output | 14 | Word captured by the last load frame |

## Verification
Every defined command is sent with its don't-care upper bits at zero and again with them at one. This separates a decoder that matches the right field width from one that compares all six bits.

Unknown values are sent between valid commands. They show whether a bad code is consumed whole, or instead shifts the framing of the command after it.

Load frames use all-ones, all-zeros and alternating words, some with start and stop bits at the opposite value. This exposes bit-order, off-by-one and start/stop-bit leaks. Read frames use two asymmetric words, checked at every rising edge together with the enable. Transfers are abandoned in mid-load and mid-read, which shows whether abort truly returns the block to command reception.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;

  localparam int CMD_BITS = 6;

  typedef enum logic [2:0] {
    CMD_LOAD_CFG   = 3'd0,
    CMD_LOAD_PGM   = 3'd1,
    CMD_READ       = 3'd2,
    CMD_INC_ADDR   = 3'd3,
    CMD_BEGIN_PGM  = 3'd4,
    CMD_END_PGM    = 3'd5,
    CMD_BULK_ERASE = 3'd6,
    CMD_ROW_ERASE  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_LOAD = 2'd1,
    ST_READ = 2'd2
  } link_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cmdShift;
    logic frmShift;
    logic wordCapture;
    logic rdLoad;
    logic oeSet;
    logic outShift;
    logic oeClr;
    logic abort;
  } dp_ctl_t;

  typedef struct packed {
    logic valid;
    cmd_e cmd;
  } dec_t;

  // four-bit codes ignore c[5:4]; five-bit codes ignore c[5]
  function automatic dec_t decodeCmd(input logic [CMD_BITS-1:0] c);
    dec_t d;
    d.valid = 1'b1;
    d.cmd   = CMD_INC_ADDR;
    if      (c[3:0] == 4'b0000)  d.cmd = CMD_LOAD_CFG;
    else if (c[3:0] == 4'b0010)  d.cmd = CMD_LOAD_PGM;
    else if (c[3:0] == 4'b0100)  d.cmd = CMD_READ;
    else if (c[3:0] == 4'b0110)  d.cmd = CMD_INC_ADDR;
    else if (c[3:0] == 4'b1001)  d.cmd = CMD_BULK_ERASE;
    else if (c[4:0] == 5'b11000) d.cmd = CMD_BEGIN_PGM;
    else if (c[4:0] == 5'b01010) d.cmd = CMD_END_PGM;
    else if (c[4:0] == 5'b10001) d.cmd = CMD_ROW_ERASE;
    else                         d.valid = 1'b0;
    return d;
  endfunction

endpackage

// File: rtl/prog_link_sync.sv
module prog_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pgmClk,
  input  logic pgmDatIn,
  output logic clkRise,
  output logic clkFall,
  output logic datBit
);
  // one extra clock stage holds the previous synchronized level
  logic [STAGES:0]   clkPipe;
  logic [STAGES-1:0] datPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[STAGES-1:0], pgmClk};
      datPipe <= {datPipe[STAGES-2:0], pgmDatIn};
    end
  end

  assign clkRise = clkPipe[STAGES-1] & ~clkPipe[STAGES];
  assign clkFall = ~clkPipe[STAGES-1] & clkPipe[STAGES];
  assign datBit  = datPipe[STAGES-1];

endmodule

// File: rtl/prog_link_ctrl.sv
module prog_link_ctrl
  import prog_link_pkg::*;
#(
  parameter int FRAME_LEN = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inMode,
  input  logic                clkRise,
  input  logic                clkFall,
  input  logic                datBit,
  input  logic [CMD_BITS-2:0] cmdHist,
  output dp_ctl_t             ctl,
  output logic                cmdValid,
  output cmd_e                cmdCode
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

  link_state_e     stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  cmd_e            pendQ, pendD;
  logic            fire;
  cmd_e            fireCode;
  dec_t            dec;

  always_comb begin
    ctl      = '0;
    stateD   = stateQ;
    cntD     = cntQ;
    pendD    = pendQ;
    fire     = 1'b0;
    fireCode = pendQ;
    dec      = decodeCmd({datBit, cmdHist});
    if (!inMode) begin
      stateD    = ST_CMD;
      cntD      = '0;
      ctl.abort = 1'b1;
    end else begin
      case (stateQ)
        ST_CMD: begin
          if (clkFall) begin
            if (cntQ == CMD_LAST) begin
              cntD = '0;
              if (dec.valid) begin
                pendD    = dec.cmd;
                fireCode = dec.cmd;
                case (dec.cmd)
                  CMD_LOAD_CFG, CMD_LOAD_PGM: stateD = ST_LOAD;
                  CMD_READ: begin
                    stateD = ST_READ;
                    fire   = 1'b1;
                  end
                  default: fire = 1'b1;
                endcase
              end
            end else begin
              ctl.cmdShift = 1'b1;
              cntD         = cntQ + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (clkFall) begin
            // data bits sit between the start and stop bit
            if (cntQ != '0 && cntQ != FRAME_LAST) ctl.frmShift = 1'b1;
            if (cntQ == FRAME_LAST) begin
              cntD            = '0;
              stateD          = ST_CMD;
              fire            = 1'b1;
              ctl.wordCapture = 1'b1;
            end else begin
              cntD = cntQ + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (clkRise) begin
            if (cntQ == '0)              ctl.rdLoad   = 1'b1;
            else if (cntQ == 1)          ctl.oeSet    = 1'b1;
            else if (cntQ != FRAME_LAST) ctl.outShift = 1'b1;
            else                         ctl.oeClr    = 1'b1;
          end
          if (clkFall) begin
            if (cntQ == FRAME_LAST) begin
              cntD   = '0;
              stateD = ST_CMD;
            end else begin
              cntD = cntQ + 1'b1;
            end
          end
        end
        default: begin
          stateD = ST_CMD;
          cntD   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_CMD;
      cntQ     <= '0;
      pendQ    <= CMD_LOAD_CFG;
      cmdValid <= 1'b0;
      cmdCode  <= CMD_LOAD_CFG;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      pendQ    <= pendD;
      cmdValid <= fire;
      if (fire) cmdCode <= fireCode;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FRAME_LAST) else $error("frame counter out of range"); // R5

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid) else $error("strobe wider than one cycle"); // R9

  AST_CMD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CMD) |-> (cntQ <= CMD_LAST)) else $error("command overrun"); // R4

endmodule

// File: rtl/prog_link_datapath.sv
module prog_link_datapath
  import prog_link_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctl_t             ctl,
  input  logic                datBit,
  input  logic [WORD_W-1:0]   rdData,
  output logic [CMD_BITS-2:0] cmdHist,
  output logic [WORD_W-1:0]   wordOut,
  output logic                datOut,
  output logic                datOe
);
  logic [WORD_W-1:0] frmSh;
  logic [WORD_W-1:0] rdSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdHist <= '0;
      frmSh   <= '0;
      wordOut <= '0;
      rdSh    <= '0;
      datOut  <= 1'b0;
      datOe   <= 1'b0;
    end else begin
      if (ctl.cmdShift)    cmdHist <= {datBit, cmdHist[CMD_BITS-2:1]};
      if (ctl.frmShift)    frmSh   <= {datBit, frmSh[WORD_W-1:1]};
      if (ctl.wordCapture) wordOut <= frmSh;
      if (ctl.rdLoad)      rdSh    <= rdData;
      if (ctl.oeSet || ctl.outShift) begin
        datOut <= rdSh[0];
        rdSh   <= {1'b0, rdSh[WORD_W-1:1]};
      end
      if (ctl.oeSet) datOe <= 1'b1;
      if (ctl.oeClr || ctl.abort) begin
        datOe  <= 1'b0;
        datOut <= 1'b0;
      end
    end
  end

  AST_OE_STARTS_ON_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datOe) |-> $past(ctl.oeSet)) else $error("enable rose without a set"); // R7

endmodule

// File: rtl/prog_link_target.sv
module prog_link_target
  import prog_link_pkg::*;
#(
  parameter int WORD_W      = 14,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inMode,
  input  logic              pgmClk,
  input  logic              pgmDatIn,
  input  logic [WORD_W-1:0] rdData,
  output logic              pgmDatOut,
  output logic              pgmDatOe,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [WORD_W-1:0] cmdWord
);
  logic                clkRise, clkFall, datBit;
  logic [CMD_BITS-2:0] cmdHist;
  dp_ctl_t             ctl;
  cmd_e                codeW;

  prog_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pgmClk   (pgmClk),
    .pgmDatIn (pgmDatIn),
    .clkRise  (clkRise),
    .clkFall  (clkFall),
    .datBit   (datBit)
  );

  prog_link_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inMode   (inMode),
    .clkRise  (clkRise),
    .clkFall  (clkFall),
    .datBit   (datBit),
    .cmdHist  (cmdHist),
    .ctl      (ctl),
    .cmdValid (cmdValid),
    .cmdCode  (codeW)
  );

  prog_link_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .datBit  (datBit),
    .rdData  (rdData),
    .cmdHist (cmdHist),
    .wordOut (cmdWord),
    .datOut  (pgmDatOut),
    .datOe   (pgmDatOe)
  );

  assign cmdCode = codeW;

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !inMode |=> (!pgmDatOe && !cmdValid)) else $error("abort left link active"); // R8

  AST_NO_STROBE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rstN)
    pgmDatOe |-> !cmdValid) else $error("strobe during read drive"); // R7

endmodule

// File: tb/prog_link_target_tb.sv
module prog_link_target_tb;
  import prog_link_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inMode = 1'b0;
  logic        pgmClk = 1'b0;
  logic        pgmDatIn = 1'b0;
  logic [13:0] rdData = '0;
  logic        pgmDatOut, pgmDatOe, cmdValid;
  logic [2:0]  cmdCode;
  logic [13:0] cmdWord;

  int errors = 0;
  int checks = 0;
  int seen   = 0;
  logic prevValid = 1'b0;

  typedef struct {
    cmd_e        code;
    logic        hasWord;
    logic [13:0] word;
  } exp_t;
  exp_t expQ[$];

  prog_link_target u_dut (
    .clk(clk), .rstN(rstN), .inMode(inMode), .pgmClk(pgmClk),
    .pgmDatIn(pgmDatIn), .rdData(rdData), .pgmDatOut(pgmDatOut),
    .pgmDatOe(pgmDatOe), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdWord(cmdWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: every clock, compare strobes with the expected queue
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid && prevValid) begin
        checks++; errors++;
        $display("FAIL R9: actual=2-cycle strobe expected=1-cycle");
      end
      if (cmdValid) begin
        seen++;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R4: actual=strobe code %0d expected=no strobe", cmdCode);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (cmdCode !== e.code) begin
            errors++;
            $display("FAIL R2: actual=%0d expected=%0d", cmdCode, e.code);
          end else if (e.hasWord && cmdWord !== e.word) begin
            errors++;
            $display("FAIL R5: actual=%0h expected=%0h", cmdWord, e.word);
          end
        end
      end
      prevValid = cmdValid;
    end
  end

  task automatic pgmBit(input logic b);
    @(negedge clk);
    pgmDatIn = b;
    pgmClk   = 1'b1;
    repeat (HALF) @(negedge clk);
    pgmClk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) pgmBit(c[i]);
  endtask

  task automatic expectCmd(input cmd_e code, input logic hasWord, input logic [13:0] w);
    exp_t e;
    e.code = code; e.hasWord = hasWord; e.word = w;
    expQ.push_back(e);
  endtask

  task automatic loadFrame(input logic [13:0] w, input logic startB, input logic stopB);
    pgmBit(startB);
    for (int i = 0; i < 14; i++) pgmBit(w[i]);
    pgmBit(stopB);
  endtask

  task automatic readFrame(input logic [13:0] val, input int abortAt);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      pgmDatIn = 1'b0;
      pgmClk   = 1'b1;
      repeat (6) @(negedge clk);
      if (k >= 2 && k <= 15) begin
        checkEq(pgmDatOe, 1, "R7 oe in window");
        checkEq(pgmDatOut, val[k-2], "R6 read bit");
      end else begin
        checkEq(pgmDatOe, 0, "R7 oe outside window");
      end
      if (k == abortAt) begin
        inMode = 1'b0;
        pgmClk = 1'b0;
        repeat (6) @(negedge clk);
        checkEq(pgmDatOe, 0, "R8 release on abort");
        checkEq(cmdValid, 0, "R8 no strobe on abort");
        inMode = 1'b1;
        repeat (2) @(negedge clk);
        return;
      end
      repeat (2) @(negedge clk);
      pgmClk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    checkEq(pgmDatOe, 0, "R7 oe after frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    // R1 reset state
    repeat (5) @(negedge clk);
    checkEq(pgmDatOe, 0, "R1 oe in reset");
    checkEq(cmdValid, 0, "R1 strobe in reset");
    rstN = 1'b1;
    // edges while out of mode must do nothing
    pgmBit(1'b0); pgmBit(1'b1);
    checkEq(pgmDatOe, 0, "R1 oe out of mode");
    checkEq(seen, 0, "R1 no strobe out of mode");
    inMode = 1'b1;
    repeat (4) @(negedge clk);

    // R2 non-data commands, upper bits zero
    expectCmd(CMD_INC_ADDR, 0, '0);   sendCmd(6'b000110);
    expectCmd(CMD_BEGIN_PGM, 0, '0);  sendCmd(6'b011000);
    expectCmd(CMD_END_PGM, 0, '0);    sendCmd(6'b001010);
    expectCmd(CMD_BULK_ERASE, 0, '0); sendCmd(6'b001001);
    expectCmd(CMD_ROW_ERASE, 0, '0);  sendCmd(6'b010001);
    checkEq(seen, 5, "R2 strobe count");

    // R3 don't-care upper bits set
    expectCmd(CMD_INC_ADDR, 0, '0);   sendCmd(6'b110110);
    expectCmd(CMD_BULK_ERASE, 0, '0); sendCmd(6'b111001);
    expectCmd(CMD_BEGIN_PGM, 0, '0);  sendCmd(6'b111000);
    expectCmd(CMD_ROW_ERASE, 0, '0);  sendCmd(6'b110001);
    expectCmd(CMD_END_PGM, 0, '0);    sendCmd(6'b101010);
    checkEq(seen, 10, "R3 strobe count");

    // R4 unknown codes consumed whole
    sendCmd(6'b000001);
    sendCmd(6'b001111);
    sendCmd(6'b111111);
    checkEq(seen, 10, "R4 no strobe for unknown");
    expectCmd(CMD_INC_ADDR, 0, '0); sendCmd(6'b000110);
    checkEq(seen, 11, "R4 framing kept after unknown");

    // R5 load frames
    expectCmd(CMD_LOAD_PGM, 1, 14'h3FFF); sendCmd(6'b000010); loadFrame(14'h3FFF, 1'b0, 1'b0);
    expectCmd(CMD_LOAD_PGM, 1, 14'h0000); sendCmd(6'b110010); loadFrame(14'h0000, 1'b1, 1'b1);
    expectCmd(CMD_LOAD_PGM, 1, 14'h2AAA); sendCmd(6'b000010); loadFrame(14'h2AAA, 1'b1, 1'b0);
    expectCmd(CMD_LOAD_CFG, 1, 14'h1555); sendCmd(6'b000000); loadFrame(14'h1555, 1'b0, 1'b1);
    checkEq(seen, 15, "R5 strobe count");
    checkEq(cmdWord, 14'h1555, "R5 word held");

    // R6 R7 read frames
    rdData = 14'h2A5C;
    expectCmd(CMD_READ, 0, '0); sendCmd(6'b000100);
    readFrame(14'h2A5C, 0);
    rdData = 14'h15A3;
    expectCmd(CMD_READ, 0, '0); sendCmd(6'b110100);
    readFrame(14'h15A3, 0);
    checkEq(seen, 17, "R6 read strobes");

    // R8 abort in a load frame
    base = seen;
    sendCmd(6'b000010);
    for (int i = 0; i < 5; i++) pgmBit(1'b1);
    @(negedge clk);
    inMode = 1'b0;
    repeat (6) @(negedge clk);
    checkEq(pgmDatOe, 0, "R8 oe after load abort");
    inMode = 1'b1;
    repeat (2) @(negedge clk);
    checkEq(seen, base, "R8 no strobe for abandoned load");
    expectCmd(CMD_INC_ADDR, 0, '0); sendCmd(6'b000110);
    checkEq(seen, base + 1, "R8 fresh command after abort");

    // R8 abort in a read frame while driving
    rdData = 14'h3C3C;
    expectCmd(CMD_READ, 0, '0); sendCmd(6'b000100);
    readFrame(14'h3C3C, 5);
    expectCmd(CMD_BULK_ERASE, 0, '0); sendCmd(6'b001001);
    checkEq(seen, base + 3, "R8 command after read abort");

    repeat (20) @(negedge clk);
    checkEq(expQ.size(), 0, "R9 all expected strobes seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule